// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Probe

This block is a fully associative translation buffer whose contents are maintained entirely by software. It holds a small set of staging registers: a virtual tag, two per-page attribute words, a page-size mask and a slot pointer. Four commands move data between those registers and the entry array: store at the pointed slot, store at a slot chosen by an external random source, search for a tag, and load a slot back into the staging registers. Each entry maps an even/odd pair of 4 KB pages that share one virtual tag.

A separate lookup port takes a virtual address and translates it against the array, using the address-space identifier currently held in the tag register. One cycle later the port reports a hit or a miss. On a hit it also returns the frame number, the valid, dirty and cache-attribute bits of the selected page half, and the full physical address. Raising exceptions from these indications is left to the surrounding pipeline.

Top module: `sw_tlb`

## Requirements
- R1: After reset all five staging registers read zero, every lookup misses and a search fails, until an entry has been stored by a command.
- R2: A register write (`reg_we_i`) targets tag (sel 0), even attributes (sel 1), odd attributes (sel 2), page mask (sel 3) or slot pointer (sel 4), and the value is visible one cycle later. The slot pointer keeps only bit 31 and the slot number, with the slot number taken as the written value modulo the entry count. A register write in a cycle with `cmd_valid_i` high is ignored.
- R3: Command code 0 stores the staging registers into the slot named by the slot pointer.
- R4: Command code 1 stores the staging registers into slot `rand_idx_i` and leaves the slot pointer unchanged.
- R5: An entry matches when its tag equals virtual bits 31:13 and either its global bit is set or its identifier equals tag-register bits 7:0. The global bit is the AND of bit 0 of both attribute words at store time.
- R6: Command code 2 searches with the tag register. On a match the pointer becomes the lowest matching slot number with bit 31 clear. On no match bit 31 is set and the slot number is kept.
- R7: Command code 3 loads the pointed slot into the staging registers. The tag register becomes the tag at bits 31:13 with the identifier at bits 7:0 and zeros elsewhere. Each attribute word is rebuilt as global at bit 0, valid at 1, dirty at 2, cache attribute at 5:3 and frame at 25:6, with zeros above. The page mask is restored.
- R8: In each attribute word, bit 1 is valid, bit 2 is dirty, bits 5:3 are the cache attribute and bits 25:6 are the frame number. The physical address is the frame number followed by virtual bits 11:0.
- R9: A lookup presented with `lk_valid_i` is answered one cycle later with `lk_done_o` high. Virtual bit 12 selects the even (0) or odd (1) page half.
- R10: On a miss, hit, valid, dirty, attribute and frame are all zero and the address carries only the page offset. A hit on a half whose valid bit is clear reports hit high with valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Staging register write strobe |
| reg_sel_i | input | 3 | Staging register select |
| reg_wdata_i | input | 32 | Staging register write data |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code |
| rand_idx_i | input | IDX_W | Slot for the random store |
| entry_hi_o | output | 32 | Tag register |
| entry_lo0_o | output | 32 | Even page attribute register |
| entry_lo1_o | output | 32 | Odd page attribute register |
| page_mask_o | output | 32 | Page mask register |
| index_o | output | 32 | Slot pointer register |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Lookup virtual address |
| lk_done_o | output | 1 | Lookup answer valid |
| lk_hit_o | output | 1 | Lookup matched an entry |
| lk_pg_valid_o | output | 1 | Selected half valid bit |
| lk_dirty_o | output | 1 | Selected half dirty bit |
| lk_attr_o | output | 3 | Selected half cache attribute |
| lk_pfn_o | output | 20 | Selected half frame number |
| lk_paddr_o | output | 32 | Translated physical address |

## Verification
A corrupted entry field appears at the ports on the next lookup that touches it, one cycle after the address is presented, as a wrong frame, attribute or hit flag. A load command exposes the same corruption on the staging registers one cycle after it is issued. A fault in the match logic shows up as a wrong pointer value the cycle after a search; duplicate tags make a wrong priority order visible. A lost or stray store is caught by looking up both page halves of each stored tag, with the identifier switched, so that a non-global entry that wrongly matches is exposed.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;
  localparam int XLEN     = 32;
  localparam int OFF_W    = 12;
  localparam int VPN_LSB  = OFF_W + 1;
  localparam int VPN_W    = XLEN - VPN_LSB;
  localparam int ASID_W   = 8;
  localparam int PFN_LSB  = 6;
  localparam int PFN_W    = XLEN - OFF_W;
  localparam int ATTR_W   = 3;

  typedef enum logic [1:0] {
    OP_WR_IDX = 2'd0,
    OP_WR_RND = 2'd1,
    OP_PROBE  = 2'd2,
    OP_READ   = 2'd3
  } tlb_op_e;

  typedef enum logic [2:0] {
    SEL_HI    = 3'd0,
    SEL_LO0   = 3'd1,
    SEL_LO1   = 3'd2,
    SEL_MASK  = 3'd3,
    SEL_INDEX = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
    logic              dirty;
    logic              valid;
  } half_t;

  typedef struct packed {
    logic              live;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [XLEN-1:0]   mask;
    logic              glob;
    half_t [1:0]       half;
  } entry_t;

  function automatic half_t lo_to_half(logic [XLEN-1:0] lo);
    half_t h;
    h.valid = lo[1];
    h.dirty = lo[2];
    h.attr  = lo[3 +: ATTR_W];
    h.pfn   = lo[PFN_LSB +: PFN_W];
    return h;
  endfunction

  function automatic logic [XLEN-1:0] half_to_lo(half_t h, logic g);
    logic [XLEN-1:0] lo;
    lo = '0;
    lo[0] = g;
    lo[1] = h.valid;
    lo[2] = h.dirty;
    lo[3 +: ATTR_W] = h.attr;
    lo[PFN_LSB +: PFN_W] = h.pfn;
    return lo;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import sw_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  entry_t [NUM_ENTRIES-1:0] ents_i,
  input  logic [VPN_W-1:0]         tag_i,
  input  logic [ASID_W-1:0]        asid_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [NUM_ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ents_i[g].live && (ents_i[g].vpn == tag_i) &&
                        (ents_i[g].glob || (ents_i[g].asid == asid_i));
  end

  // lowest slot wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import sw_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         widx_i,
  input  entry_t                   wentry_i,
  output entry_t [NUM_ENTRIES-1:0] ents_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ents_o[g] <= '0;
      end else if (we_i && (widx_i == IDX_W'(g))) begin
        ents_o[g] <= wentry_i;
      end
    end
  end
endmodule

// File: rtl/tlb_cp_regs.sv
module tlb_cp_regs
  import sw_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_sel_i,
  input  logic [XLEN-1:0]  reg_wdata_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic             probe_hit_i,
  input  logic [IDX_W-1:0] probe_idx_i,
  input  entry_t           rd_entry_i,
  output logic [XLEN-1:0]  hi_o,
  output logic [XLEN-1:0]  lo0_o,
  output logic [XLEN-1:0]  lo1_o,
  output logic [XLEN-1:0]  mask_o,
  output logic             fail_o,
  output logic [IDX_W-1:0] idx_o
);
  tlb_op_e  op;
  reg_sel_e sel;
  assign op  = tlb_op_e'(cmd_op_i);
  assign sel = reg_sel_e'(reg_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o   <= '0;
      lo0_o  <= '0;
      lo1_o  <= '0;
      mask_o <= '0;
      fail_o <= 1'b0;
      idx_o  <= '0;
    end else if (cmd_valid_i) begin
      unique case (op)
        OP_PROBE: begin
          fail_o <= !probe_hit_i;
          if (probe_hit_i) idx_o <= probe_idx_i;
        end
        OP_READ: begin
          hi_o   <= {rd_entry_i.vpn, {(VPN_LSB - ASID_W){1'b0}}, rd_entry_i.asid};
          lo0_o  <= half_to_lo(rd_entry_i.half[0], rd_entry_i.glob);
          lo1_o  <= half_to_lo(rd_entry_i.half[1], rd_entry_i.glob);
          mask_o <= rd_entry_i.mask;
        end
        default: ;
      endcase
    end else if (reg_we_i) begin
      unique case (sel)
        SEL_HI:    hi_o   <= reg_wdata_i;
        SEL_LO0:   lo0_o  <= reg_wdata_i;
        SEL_LO1:   lo1_o  <= reg_wdata_i;
        SEL_MASK:  mask_o <= reg_wdata_i;
        SEL_INDEX: begin
          fail_o <= reg_wdata_i[XLEN-1];
          idx_o  <= IDX_W'(reg_wdata_i % XLEN'(NUM_ENTRIES));
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tlb_lookup_stage.sv
module tlb_lookup_stage
  import sw_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [XLEN-1:0]          vaddr_i,
  input  logic                     hit_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  entry_t [NUM_ENTRIES-1:0] ents_i,
  output logic                     done_o,
  output logic                     hit_o,
  output half_t                    half_o,
  output logic [OFF_W-1:0]         off_o
);
  half_t sel_half;
  assign sel_half = ents_i[idx_i].half[vaddr_i[OFF_W]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      hit_o  <= 1'b0;
      half_o <= '0;
      off_o  <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        hit_o  <= hit_i;
        half_o <= hit_i ? sel_half : '0;
        off_o  <= vaddr_i[OFF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import sw_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_sel_i,
  input  logic [31:0]        reg_wdata_i,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_op_i,
  input  logic [IDX_W-1:0]   rand_idx_i,
  output logic [31:0]        entry_hi_o,
  output logic [31:0]        entry_lo0_o,
  output logic [31:0]        entry_lo1_o,
  output logic [31:0]        page_mask_o,
  output logic [31:0]        index_o,
  input  logic               lk_valid_i,
  input  logic [31:0]        lk_vaddr_i,
  output logic               lk_done_o,
  output logic               lk_hit_o,
  output logic               lk_pg_valid_o,
  output logic               lk_dirty_o,
  output logic [2:0]         lk_attr_o,
  output logic [19:0]        lk_pfn_o,
  output logic [31:0]        lk_paddr_o
);
  entry_t [NUM_ENTRIES-1:0] ents;
  entry_t                   new_ent;
  logic                     wr_en;
  logic [IDX_W-1:0]         wr_idx;
  logic [IDX_W-1:0]         cur_idx;
  logic                     idx_fail;
  logic                     probe_hit;
  logic [IDX_W-1:0]         probe_idx;
  logic                     lk_hit;
  logic [IDX_W-1:0]         lk_idx;
  half_t                    lk_half;
  logic [OFF_W-1:0]         lk_off;

  assign wr_en  = cmd_valid_i && ((cmd_op_i == OP_WR_IDX) || (cmd_op_i == OP_WR_RND));
  assign wr_idx = (cmd_op_i == OP_WR_RND) ? rand_idx_i : cur_idx;

  always_comb begin
    new_ent      = '0;
    new_ent.live = 1'b1;
    new_ent.vpn  = entry_hi_o[XLEN-1:VPN_LSB];
    new_ent.asid = entry_hi_o[ASID_W-1:0];
    new_ent.mask = page_mask_o;
    new_ent.glob = entry_lo0_o[0] & entry_lo1_o[0];
    new_ent.half[0] = lo_to_half(entry_lo0_o);
    new_ent.half[1] = lo_to_half(entry_lo1_o);
  end

  tlb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk_i, .rst_ni,
    .we_i(wr_en), .widx_i(wr_idx), .wentry_i(new_ent), .ents_o(ents)
  );

  tlb_cp_regs #(.NUM_ENTRIES(NUM_ENTRIES)) u_regs (
    .clk_i, .rst_ni,
    .reg_we_i, .reg_sel_i, .reg_wdata_i, .cmd_valid_i, .cmd_op_i,
    .probe_hit_i(probe_hit), .probe_idx_i(probe_idx), .rd_entry_i(ents[cur_idx]),
    .hi_o(entry_hi_o), .lo0_o(entry_lo0_o), .lo1_o(entry_lo1_o),
    .mask_o(page_mask_o), .fail_o(idx_fail), .idx_o(cur_idx)
  );

  assign index_o = {idx_fail, {(XLEN - 1 - IDX_W){1'b0}}, cur_idx};

  tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_probe_cmp (
    .ents_i(ents), .tag_i(entry_hi_o[XLEN-1:VPN_LSB]), .asid_i(entry_hi_o[ASID_W-1:0]),
    .hit_o(probe_hit), .idx_o(probe_idx)
  );

  tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_lk_cmp (
    .ents_i(ents), .tag_i(lk_vaddr_i[XLEN-1:VPN_LSB]), .asid_i(entry_hi_o[ASID_W-1:0]),
    .hit_o(lk_hit), .idx_o(lk_idx)
  );

  tlb_lookup_stage #(.NUM_ENTRIES(NUM_ENTRIES)) u_lk_stage (
    .clk_i, .rst_ni,
    .valid_i(lk_valid_i), .vaddr_i(lk_vaddr_i), .hit_i(lk_hit), .idx_i(lk_idx),
    .ents_i(ents), .done_o(lk_done_o), .hit_o(lk_hit_o), .half_o(lk_half), .off_o(lk_off)
  );

  assign lk_pg_valid_o = lk_half.valid;
  assign lk_dirty_o    = lk_half.dirty;
  assign lk_attr_o     = lk_half.attr;
  assign lk_pfn_o      = lk_half.pfn;
  assign lk_paddr_o    = {lk_half.pfn, lk_off};
endmodule

// File: rtl/sw_tlb_chk.sv
module sw_tlb_chk #(
  parameter int NUM_ENTRIES = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [2:0]  reg_sel_i,
  input logic [31:0] reg_wdata_i,
  input logic        cmd_valid_i,
  input logic [1:0]  cmd_op_i,
  input logic [31:0] entry_hi_o,
  input logic [31:0] index_o,
  input logic        lk_valid_i,
  input logic        lk_done_o,
  input logic        lk_hit_o,
  input logic        lk_pg_valid_o,
  input logic [19:0] lk_pfn_o,
  input logic        probe_hit
);
  logic seen_wr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_wr_q <= 1'b0;
    else if (cmd_valid_i && !cmd_op_i[1]) seen_wr_q <= 1'b1;
  end

  AST_NO_HIT_BEFORE_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_done_o && lk_hit_o) |-> seen_wr_q); // R1
  AST_HI_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !cmd_valid_i && reg_sel_i == 3'd0) |=> entry_hi_o == $past(reg_wdata_i)); // R2
  AST_CMD_BLOCKS_REG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && cmd_valid_i && !cmd_op_i[1]) |=> $stable(entry_hi_o)); // R2
  AST_RND_KEEPS_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd1) |=> $stable(index_o)); // R4
  AST_PROBE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd2) |=> index_o[31] == !$past(probe_hit)); // R6
  AST_LK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_done_o); // R9
  AST_LK_NO_STRAY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !lk_done_o); // R9
  AST_MISS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_done_o && !lk_hit_o) |-> (lk_pfn_o == '0 && !lk_pg_valid_o)); // R10
endmodule

bind sw_tlb sw_tlb_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
  .reg_wdata_i(reg_wdata_i), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .entry_hi_o(entry_hi_o), .index_o(index_o), .lk_valid_i(lk_valid_i),
  .lk_done_o(lk_done_o), .lk_hit_o(lk_hit_o), .lk_pg_valid_o(lk_pg_valid_o),
  .lk_pfn_o(lk_pfn_o), .probe_hit(probe_hit)
);

// File: tb/sw_tlb_tb.sv
module sw_tlb_tb;
  localparam int N = 16;
  localparam int IW = $clog2(N);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [IW-1:0] rand_idx = '0;
  logic [31:0] hi, lo0, lo1, pmask, idx;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_done, lk_hit, lk_v, lk_d;
  logic [2:0]  lk_c;
  logic [19:0] lk_pfn;
  logic [31:0] lk_pa;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    logic hit; logic [19:0] pfn; logic v; logic d; logic [2:0] c; logic [31:0] pa;
  } lk_exp_t;
  lk_exp_t exp_q[$];

  always #5 clk = ~clk;

  sw_tlb #(.NUM_ENTRIES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .rand_idx_i(rand_idx),
    .entry_hi_o(hi), .entry_lo0_o(lo0), .entry_lo1_o(lo1), .page_mask_o(pmask), .index_o(idx),
    .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_done_o(lk_done), .lk_hit_o(lk_hit),
    .lk_pg_valid_o(lk_v), .lk_dirty_o(lk_d), .lk_attr_o(lk_c), .lk_pfn_o(lk_pfn), .lk_paddr_o(lk_pa)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regw(logic [2:0] sel, logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cmd(logic [1:0] op);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic lk(string tag, logic [31:0] va, logic h, logic [19:0] pfn,
                    logic v, logic d, logic [2:0] c);
    lk_exp_t e;
    e.tag = tag; e.hit = h; e.pfn = pfn; e.v = v; e.d = d; e.c = c;
    e.pa = {pfn, va[11:0]};
    exp_q.push_back(e);
    lk_valid = 1'b1; lk_vaddr = va;
    @(negedge clk);
  endtask

  task automatic lk_idle();
    lk_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && lk_done) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 unexpected lookup answer act=1 exp=0");
      end else begin
        lk_exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " hit"}, 32'(lk_hit), 32'(e.hit));
        chk({e.tag, " pfn"}, 32'(lk_pfn), 32'(e.pfn));
        chk({e.tag, " v/d/c"}, {27'b0, lk_v, lk_d, lk_c}, {27'b0, e.v, e.d, e.c});
        chk({e.tag, " paddr"}, lk_pa, e.pa);
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 hi", hi, 32'h0);
    chk("R1 lo0", lo0, 32'h0);
    chk("R1 lo1", lo1, 32'h0);
    chk("R1 mask", pmask, 32'h0);
    chk("R1 index", idx, 32'h0);
    lk("R1 lookup before store", 32'h0000_0000, 1'b0, 20'h0, 1'b0, 1'b0, 3'd0);
    lk_idle();
    cmd(2'd2);
    chk("R1 R6 probe before store", idx, 32'h8000_0000);

    // R2 staging writes, R3 indexed store into slot 3
    regw(3'd3, 32'h0000_1800);
    regw(3'd0, 32'h1234_6005);
    regw(3'd1, 32'h02AF_379F);
    regw(3'd2, 32'h0044_4452);
    regw(3'd4, 32'h0000_0013);
    chk("R2 index modulo", idx, 32'h0000_0003);
    chk("R2 hi", hi, 32'h1234_6005);
    chk("R2 lo0", lo0, 32'h02AF_379F);
    chk("R2 lo1", lo1, 32'h0044_4452);
    chk("R2 mask", pmask, 32'h0000_1800);
    cmd(2'd0);

    // R8 R9 back-to-back lookups, even then odd half
    lk("R8 R9 even half", 32'h1234_6ABC, 1'b1, 20'hABCDE, 1'b1, 1'b1, 3'd3);
    lk("R8 R9 odd half", 32'h1234_7123, 1'b1, 20'h11111, 1'b1, 1'b0, 3'd2);
    lk_idle();

    // R5 identifier mismatch on non-global entry
    regw(3'd0, 32'h1234_6009);
    lk("R5 asid mismatch", 32'h1234_6ABC, 1'b0, 20'h0, 1'b0, 1'b0, 3'd0);
    lk_idle();

    // R5 global entry in slot 5, R10 not-valid half
    regw(3'd0, 32'h0040_0007);
    regw(3'd1, 32'h0000_4003);
    regw(3'd2, 32'h0000_0001);
    regw(3'd4, 32'h0000_0005);
    cmd(2'd0);
    regw(3'd0, 32'h0040_00FF);
    lk("R5 global hit", 32'h0040_0010, 1'b1, 20'h00100, 1'b1, 1'b0, 3'd0);
    lk("R10 not-valid half", 32'h0040_1010, 1'b1, 20'h0, 1'b0, 1'b0, 3'd0);
    lk("R10 miss", 32'h5550_0FFF, 1'b0, 20'h0, 1'b0, 1'b0, 3'd0);
    lk_idle();

    // R4 random store into slot 10
    regw(3'd0, 32'h7000_0042);
    regw(3'd1, 32'h0088_8882);
    regw(3'd2, 32'h0000_0000);
    rand_idx = 4'd10;
    cmd(2'd1);
    chk("R4 index kept", idx, 32'h0000_0005);
    lk("R4 random slot lookup", 32'h7000_0123, 1'b1, 20'h22222, 1'b1, 1'b0, 3'd0);
    lk_idle();

    // R6 duplicate in slot 12, lowest match wins; R2 write blocked by command
    regw(3'd4, 32'h0000_000C);
    cmd(2'd0);
    reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 32'hDEAD_0000;
    cmd(2'd2);
    reg_we = 1'b0;
    chk("R2 write ignored during command", hi, 32'h7000_0042);
    chk("R6 R4 probe lowest slot", idx, 32'h0000_000A);

    regw(3'd0, 32'h7FFF_E042);
    cmd(2'd2);
    chk("R6 probe miss keeps slot", idx, 32'h8000_000A);

    // R7 R3 load slot 3 back
    regw(3'd4, 32'h0000_0003);
    cmd(2'd3);
    chk("R7 R3 hi", hi, 32'h1234_6005);
    chk("R7 R3 lo0", lo0, 32'h02AF_379E);
    chk("R7 R3 lo1", lo1, 32'h0044_4452);
    chk("R7 R3 mask", pmask, 32'h0000_1800);

    regw(3'd4, 32'h0000_0005);
    cmd(2'd3);
    chk("R7 global hi", hi, 32'h0040_0007);
    chk("R7 global lo0", lo0, 32'h0000_4003);
    chk("R7 global lo1", lo1, 32'h0000_0001);

    repeat (2) @(negedge clk);
    chk("R9 all lookups answered", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule